// File: doc/BRIEF.md
# Exception Entry Sequencer

This block walks a processor core through the entry into an exception or interrupt handler. A request arrives with a two-bit cause code. The block picks the handler vector for that cause, works out the return address and the new status word, and decides whether to swap stack pointers. It then reads the handler address from a vector table through a single-word read port. When the read returns, the block presents the new PC and the register updates for one cycle, together with a `done` pulse.

Two core generations are supported. A version input below a parameterised threshold selects the legacy behaviour. The legacy path leaves the status word unshifted, writes no exception-status register, does no delay-slot rewind and raises an interrupt-lock flag. It also has no way to handle a bus fault, so a bus fault on a legacy core is treated as fatal. The newer path records the vector index in the exception-status register. It shifts the mode bits of the status word into a history field and rewinds the saved return address over a pending delay slot.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause 0 (break) uses `trap_vec` and writes the return value to ERP (`erp_we`). The return value is `cur_pc`, less any delay-slot rewind (R6).
- R2: Cause 1 (NMI) uses vector 0 and writes the return value to NRP (`nrp_we`) instead of ERP. It clears bit `M_BIT` (default 30) of the status word before any shift is applied.
- R3: Cause 2 (bus fault) uses `fault_vec` and writes to ERP. A cause-2 request seen while a cause-2 sequence is still in progress sets `abort`.
- R4: Cause 3 (external interrupt) uses `irq_vec` and writes to ERP.
- R5: On the newer core, `exs_we` is asserted and `exs_val` holds the vector in bits 15:8, with every other bit zero.
- R6: On the newer core, a non-zero `dslot` is subtracted from the saved return value and `dslot_clr` is asserted. The legacy core does neither.
- R7: When bit `U_BIT` (default 16) of `cur_ccs` is set, `sp_swap` is asserted, `usp_val` carries `cur_sp` and `sp_val` carries `cur_ksp`.
- R8: On the newer core, `ccs_val` keeps bits 31:30, takes old bits 19:0 into bits 29:10, and has zeros in bits 9:0.
- R9: The table read is issued at address `cur_ebp + 4*vector` and held with a stable address until `mem_ack`. `new_pc` takes `mem_rdata`.
- R10: A `version` below `LEGACY_BELOW` (default 32) selects the legacy path. On that path `ccs_val` is the unshifted word (with only the NMI M clear applied), `exs_we` stays low and `irq_lock` is asserted. A legacy cause-2 request sets `abort` and starts no sequence.
- R11: A request taken while idle raises `busy` on the next cycle. `done` is a one-cycle pulse in the cycle after the acknowledged read. Requests made while `busy` is high do not start a sequence.
- R12: `abort` is sticky until reset. While it is set, no new sequence is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request |
| req_cause | input | 2 | 0 break, 1 NMI, 2 bus fault, 3 interrupt |
| trap_vec | input | VW | Vector from trap logic |
| fault_vec | input | VW | Vector from fault logic |
| irq_vec | input | VW | Vector from interrupt controller |
| version | input | VERW | Core version value |
| cur_pc | input | DW | Current PC |
| cur_ccs | input | DW | Current status word |
| cur_ebp | input | DW | Vector table base |
| cur_sp | input | DW | Current stack pointer |
| cur_ksp | input | DW | Kernel stack pointer |
| dslot | input | DSW | Pending delay-slot count |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | DW | Vector read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| done | output | 1 | Results valid for this cycle |
| new_pc | output | DW | Handler address |
| ret_val | output | DW | Saved return address |
| erp_we | output | 1 | Write ret_val to ERP |
| nrp_we | output | 1 | Write ret_val to NRP |
| ccs_val | output | DW | New status word |
| exs_we | output | 1 | Write exs_val |
| exs_val | output | DW | Exception-status value |
| sp_swap | output | 1 | Perform stack swap |
| usp_val | output | DW | Value for user stack pointer |
| sp_val | output | DW | Value for SP |
| dslot_clr | output | 1 | Clear delay-slot state |
| irq_lock | output | 1 | Legacy interrupt lock |
| abort | output | 1 | Fatal fault, sticky |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, 8-bit vectors, a 2-bit delay-slot count and a legacy threshold of 32. This makes the fixed 31:30 / 19:0 status shift and the 15:8 index field directly checkable. Read latencies of zero to four cycles bring the address-hold and wait behaviour within reach. Separate reset phases exercise the recursive bus-fault abort and the legacy bus-fault abort, along with the requests that are ignored afterwards.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int DW           = 32,
  parameter int VW           = 8,
  parameter int DSW          = 2,
  parameter int VERW         = 8,
  parameter int LEGACY_BELOW = 32,
  parameter int M_BIT        = 30,
  parameter int U_BIT        = 16,
  parameter int HIST_SH      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_cause,
  input  logic [VW-1:0]   trap_vec,
  input  logic [VW-1:0]   fault_vec,
  input  logic [VW-1:0]   irq_vec,
  input  logic [VERW-1:0] version,
  input  logic [DW-1:0]   cur_pc,
  input  logic [DW-1:0]   cur_ccs,
  input  logic [DW-1:0]   cur_ebp,
  input  logic [DW-1:0]   cur_sp,
  input  logic [DW-1:0]   cur_ksp,
  input  logic [DSW-1:0]  dslot,
  output logic            busy,
  output logic            mem_req,
  output logic [DW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic [DW-1:0]   new_pc,
  output logic [DW-1:0]   ret_val,
  output logic            erp_we,
  output logic            nrp_we,
  output logic [DW-1:0]   ccs_val,
  output logic            exs_we,
  output logic [DW-1:0]   exs_val,
  output logic            sp_swap,
  output logic [DW-1:0]   usp_val,
  output logic [DW-1:0]   sp_val,
  output logic            dslot_clr,
  output logic            irq_lock,
  output logic            abort
);
  localparam logic [1:0] C_BRK = 2'd0;
  localparam logic [1:0] C_NMI = 2'd1;
  localparam logic [1:0] C_BF  = 2'd2;
  localparam int EXS_LO = 8;
  localparam logic [DW-1:0] M_MASK = ~(DW'(1) << M_BIT);

  logic            busy_q, abort_q, done_q;
  logic [1:0]      p_cause;
  logic [DW-1:0]   p_ret, p_ccs, p_exs, p_usp, p_sp, p_addr;
  logic            p_exs_we, p_swap, p_lock, p_dclr;
  logic [DW-1:0]   o_pc, o_ret, o_ccs, o_exs, o_usp, o_sp;
  logic            o_nmi, o_exs_we, o_swap, o_lock, o_dclr;
  logic [VW-1:0]   vec;

  wire legacy = version < VERW'(LEGACY_BELOW);
  wire legacy_bf = !busy_q && req_valid && legacy && req_cause == C_BF;
  wire recursive_bf = busy_q && req_valid && p_cause == C_BF && req_cause == C_BF;
  wire take = !busy_q && !abort_q && req_valid && !legacy_bf;

  always_comb
    case (req_cause)
      C_BRK:   vec = trap_vec;
      C_NMI:   vec = '0;
      C_BF:    vec = fault_vec;
      default: vec = irq_vec;
    endcase

  wire [DW-1:0] ccs_m  = (req_cause == C_NMI) ? (cur_ccs & M_MASK) : cur_ccs;
  wire [DW-1:0] ccs_sh = {ccs_m[DW-1:DW-2], ccs_m[DW-3-HIST_SH:0], {HIST_SH{1'b0}}};
  wire          rewind = !legacy && dslot != '0;
  wire [DW-1:0] ret_c  = cur_pc - (rewind ? DW'(dslot) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      abort_q <= 1'b0;
      done_q <= 1'b0;
      p_cause <= C_BRK;
      p_ret <= '0; p_ccs <= '0; p_exs <= '0; p_usp <= '0; p_sp <= '0; p_addr <= '0;
      p_exs_we <= 1'b0; p_swap <= 1'b0; p_lock <= 1'b0; p_dclr <= 1'b0;
      o_pc <= '0; o_ret <= '0; o_ccs <= '0; o_exs <= '0; o_usp <= '0; o_sp <= '0;
      o_nmi <= 1'b0; o_exs_we <= 1'b0; o_swap <= 1'b0; o_lock <= 1'b0; o_dclr <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!abort_q && (legacy_bf || recursive_bf))
        abort_q <= 1'b1;
      if (take) begin
        busy_q   <= 1'b1;
        p_cause  <= req_cause;
        p_ret    <= ret_c;
        p_ccs    <= legacy ? ccs_m : ccs_sh;
        p_exs_we <= !legacy;
        p_exs    <= legacy ? '0 : (DW'(vec) << EXS_LO);
        p_swap   <= cur_ccs[U_BIT];
        p_usp    <= cur_sp;
        p_sp     <= cur_ksp;
        p_lock   <= legacy;
        p_dclr   <= rewind;
        p_addr   <= cur_ebp + (DW'(vec) << 2);
      end else if (busy_q && mem_ack) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        o_pc     <= mem_rdata;
        o_ret    <= p_ret;
        o_nmi    <= p_cause == C_NMI;
        o_ccs    <= p_ccs;
        o_exs_we <= p_exs_we;
        o_exs    <= p_exs;
        o_swap   <= p_swap;
        o_usp    <= p_usp;
        o_sp     <= p_sp;
        o_lock   <= p_lock;
        o_dclr   <= p_dclr;
      end
    end
  end

  assign busy      = busy_q;
  assign abort     = abort_q;
  assign done      = done_q;
  assign mem_req   = busy_q;
  assign mem_addr  = p_addr;
  assign new_pc    = o_pc;
  assign ret_val   = o_ret;
  assign erp_we    = done_q && !o_nmi;
  assign nrp_we    = done_q && o_nmi;
  assign ccs_val   = o_ccs;
  assign exs_we    = done_q && o_exs_we;
  assign exs_val   = o_exs;
  assign sp_swap   = done_q && o_swap;
  assign usp_val   = o_usp;
  assign sp_val    = o_sp;
  assign dslot_clr = done_q && o_dclr;
  assign irq_lock  = done_q && o_lock;

  p_done_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ack));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_one_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({erp_we, nrp_we}) == 1);
  p_exs_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exs_we |-> exs_val[EXS_LO-1:0] == '0 && exs_val[DW-1:EXS_LO+VW] == '0);
  p_abort_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> abort);
  p_legacy_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lock |-> !exs_we && !dslot_clr);
  p_no_start_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !busy |=> !busy);
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1357_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_cause = 0;
  logic [7:0] trap_vec = 8'h11, fault_vec = 8'h22, irq_vec = 8'h33, version = 8'd40;
  logic [31:0] cur_pc = 0, cur_ccs = 0, cur_ebp = 0, cur_sp = 0, cur_ksp = 0;
  logic [1:0] dslot = 0;
  logic busy, mem_req, mem_ack, done, erp_we, nrp_we, exs_we, sp_swap, dslot_clr, irq_lock, abort;
  logic [31:0] mem_addr, mem_rdata, new_pc, ret_val, ccs_val, exs_val, usp_val, sp_val;

  int tests = 0, fails = 0, lat = 0;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
    .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec), .version(version),
    .cur_pc(cur_pc), .cur_ccs(cur_ccs), .cur_ebp(cur_ebp), .cur_sp(cur_sp), .cur_ksp(cur_ksp),
    .dslot(dslot), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .new_pc(new_pc), .ret_val(ret_val), .erp_we(erp_we),
    .nrp_we(nrp_we), .ccs_val(ccs_val), .exs_we(exs_we), .exs_val(exs_val), .sp_swap(sp_swap),
    .usp_val(usp_val), .sp_val(sp_val), .dslot_clr(dslot_clr), .irq_lock(irq_lock), .abort(abort));

  always #(PERIOD/2) clk = ~clk;

  // reference model
  bit m_busy, m_done, m_abort, m_nmi, m_exs_we, m_swap, m_lock, m_dclr;
  int m_wait;
  logic [1:0]  m_cause;
  logic [31:0] m_addr, m_pc, m_ret, m_ccs, m_exs, m_usp, m_sp;
  logic [31:0] q_ret, q_ccs, q_exs, q_usp, q_sp;
  bit q_nmi, q_exs_we, q_swap, q_lock, q_dclr;
  bit r_busy; int r_wait;

  assign mem_ack = r_busy && (r_wait >= lat);
  assign mem_rdata = mem_addr ^ KEY;

  function automatic logic [31:0] hist_shift(logic [31:0] c);
    return ((c & 32'hC000_0000) | ((c << 12) >> 2)) & ~32'h3FF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_abort = 0; m_wait = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (req_valid && req_cause == 2 && m_cause == 2) m_abort = 1;
        if (m_wait >= lat) begin
          m_busy = 0; m_done = 1; m_pc = m_addr ^ KEY;
          m_ret = q_ret; m_ccs = q_ccs; m_exs = q_exs; m_usp = q_usp; m_sp = q_sp;
          m_nmi = q_nmi; m_exs_we = q_exs_we; m_swap = q_swap; m_lock = q_lock; m_dclr = q_dclr;
        end else m_wait++;
      end else if (!m_abort && req_valid) begin
        bit leg;
        int v;
        logic [31:0] c;
        leg = version < 32;
        if (leg && req_cause == 2) m_abort = 1;
        else begin
          v = (req_cause == 0) ? int'(trap_vec) : (req_cause == 1) ? 0 :
              (req_cause == 2) ? int'(fault_vec) : int'(irq_vec);
          c = cur_ccs;
          if (req_cause == 1) c[30] = 0;
          q_ccs = leg ? c : hist_shift(c);
          q_ret = cur_pc - (leg ? 0 : int'(dslot));
          q_exs = v * 256; q_exs_we = !leg; q_nmi = req_cause == 1;
          q_swap = cur_ccs[16]; q_usp = cur_sp; q_sp = cur_ksp;
          q_lock = leg; q_dclr = !leg && dslot != 0;
          m_addr = cur_ebp + v * 4; m_cause = req_cause;
          m_busy = 1; m_wait = 0;
        end
      end
    end
    r_busy <= m_busy; r_wait <= m_wait;
  end

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h at %0t", r, act, exp, $time); end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(busy == m_busy, "R11 busy", 32'(busy), 32'(m_busy));
    chk(mem_req == m_busy, "R9 mem_req", 32'(mem_req), 32'(m_busy));
    if (m_busy) chk(mem_addr == m_addr, "R9 mem_addr", mem_addr, m_addr);
    chk(done == m_done, "R11 done", 32'(done), 32'(m_done));
    chk(abort == m_abort, "R3/R12 abort", 32'(abort), 32'(m_abort));
    if (m_done) begin
      chk(new_pc == m_pc, "R9 new_pc", new_pc, m_pc);
      chk(ret_val == m_ret, "R1/R6 ret_val", ret_val, m_ret);
      chk(erp_we == !m_nmi, "R1/R3/R4 erp_we", 32'(erp_we), 32'(!m_nmi));
      chk(nrp_we == m_nmi, "R2 nrp_we", 32'(nrp_we), 32'(m_nmi));
      chk(ccs_val == m_ccs, "R8/R10 ccs_val", ccs_val, m_ccs);
      chk(exs_we == m_exs_we, "R5 exs_we", 32'(exs_we), 32'(m_exs_we));
      if (m_exs_we) chk(exs_val == m_exs, "R5 exs_val", exs_val, m_exs);
      chk(sp_swap == m_swap, "R7 sp_swap", 32'(sp_swap), 32'(m_swap));
      if (m_swap) begin
        chk(usp_val == m_usp, "R7 usp_val", usp_val, m_usp);
        chk(sp_val == m_sp, "R7 sp_val", sp_val, m_sp);
      end
      chk(dslot_clr == m_dclr, "R6 dslot_clr", 32'(dslot_clr), 32'(m_dclr));
      chk(irq_lock == m_lock, "R10 irq_lock", 32'(irq_lock), 32'(m_lock));
    end else begin
      chk(!erp_we && !nrp_we && !exs_we && !sp_swap && !irq_lock && !dslot_clr,
          "R11 strobes idle", 32'({erp_we, nrp_we, exs_we, sp_swap}), 0);
    end
  end

  task automatic fire(logic [1:0] c, logic [7:0] ver, logic [31:0] pc, logic [31:0] ccs,
                      logic [1:0] ds, int l);
    @(negedge clk); #1;
    lat = l; req_cause = c; version = ver; cur_pc = pc; cur_ccs = ccs; dslot = ds;
    cur_ebp = 32'h0000_8000 + pc[11:0]; cur_sp = pc ^ 32'hFFFF; cur_ksp = pc + 32'h100;
    req_valid = 1;
    @(negedge clk); #1; req_valid = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst_n = 0;
    @(negedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !abort && !mem_req, "R11 reset state", 32'({busy, done, abort}), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !abort && !mem_req, "R11 reset state", 32'({busy, done, abort}), 0);
    fire(0, 40, 32'h0000_1000, 32'h0000_0000, 0, 0);   // R1 break
    fire(0, 40, 32'h0000_2004, 32'h4001_2345, 2, 2);   // R6 rewind, R8 shift
    fire(1, 40, 32'h0000_3008, 32'hC001_0ABC, 1, 1);   // R2 NMI, R7 swap
    fire(2, 40, 32'h0000_400C, 32'h0001_0001, 0, 3);   // R3 bus fault
    fire(3, 40, 32'h0000_5010, 32'hFFFF_FFFF, 3, 4);   // R4 irq
    fire(3, 10, 32'h0000_6014, 32'h8001_00F0, 2, 1);   // R10 legacy irq
    fire(1, 31, 32'h0000_7018, 32'hC000_FFFF, 1, 0);   // R10 legacy NMI
    fire(0, 32, 32'h0000_801C, 32'h0001_0000, 0, 2);   // R10 boundary: newer
    // R11: request during busy is ignored
    @(negedge clk); #1;
    lat = 4; req_cause = 3; version = 40; cur_pc = 32'h9020; cur_ebp = 32'h9000; req_valid = 1;
    @(negedge clk); #1; req_cause = 0; trap_vec = 8'h77;
    @(negedge clk); #1; req_valid = 0;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    // R3: recursive bus fault
    do_reset();
    @(negedge clk); #1;
    lat = 4; req_cause = 2; req_valid = 1;
    @(negedge clk); #1;
    @(negedge clk); #1; req_valid = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    chk(abort == 1, "R3 recursive abort", 32'(abort), 1);
    // R12: no sequence after abort
    @(negedge clk); #1; req_cause = 3; req_valid = 1;
    repeat (2) @(negedge clk); #1; req_valid = 0;
    chk(!busy, "R12 ignored after abort", 32'(busy), 0);
    // R10: legacy bus fault aborts
    do_reset();
    fire(2, 5, 32'h0000_A000, 0, 0, 1);
    chk(abort == 1 && !busy, "R10 legacy bus fault abort", 32'({abort, busy}), 32'b10);
    fire(0, 40, 32'h0000_B000, 0, 0, 0);
    chk(!done, "R12 no start after abort", 32'(done), 0);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule